// File: doc/BRIEF.md
# Change-of-State Input Interrupt Detector

This block monitors sixteen digital input channels and raises a single interrupt request when a programmed change-of-state condition occurs. Every channel first passes through a two-flop synchroniser. Two masks then select which channels take part. The "high" mask makes a channel sensitive to a rising edge or to a high level. The "low" mask makes a channel sensitive to a falling edge or to a low level.

A control register enables the detector and picks the combining rule. In OR mode, an edge on any selected channel fires. In AND mode, the detector fires only when every selected channel sits at its chosen level at the same time. After an AND-mode firing, the combined condition must drop away before the detector can fire again.

The interrupt line is sticky. It stays high until the host reads the status register, which reports the channels that caused the firing and clears itself on that read. All registers are reached through a simple synchronous bus. A read returns data combinationally in the cycle the select is high, and takes effect at the next clock edge.

Top module: `cos_irq_detector`

## Requirements
- R1: After reset, `irq` is low and every register (control 0x0, high mask 0x4, low mask 0x8, status 0xC) reads zero.
- R2: The control register keeps only bit 2 (enable) and bit 1 (mode: 0 = OR, 1 = AND); the mask registers keep bits 15:0; all other bits read zero; writes to the status offset have no effect.
- R3: In OR mode, a 0-to-1 change on a channel set in the high mask sets `irq` on the third rising clock edge after the input change (not on the second), and status then reads that channel's bit alone.
- R4: In OR mode, a 1-to-0 change on a channel set in the low mask sets `irq` on the third clock edge after the change; a 0-to-1 change on that channel does not.
- R5: In OR mode, channels not set in either mask never raise `irq`; a channel set in both masks fires on both edge directions.
- R6: In AND mode, `irq` is set on the third clock edge after every channel in the high mask is high and every channel in the low mask is low; status then reads the union of both masks.
- R7: After an AND-mode firing, no further firing occurs while the condition stays true, even once status has been read; after the condition is released and met again, it fires again.
- R8: In AND mode, a channel set in both masks makes the condition unreachable, and an AND-mode configuration with both masks empty never fires.
- R9: `irq` stays high until a status read; that read returns the recorded channels and clears `irq` and status, except when a new firing lands on the same edge, which is then recorded alone.
- R10: With control bit 2 clear (including control written to zero), no input activity raises `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_sel` is high and `bus_we` is low |
| chan_in | input | 16 | Asynchronous digital input channels |
| irq | output | 1 | Sticky interrupt request |

## Verification
The assertions take the bus to be single-cycle, with one access per select pulse. They also assume that a mask or mode change is not made in the same cycle as a firing whose status they inspect. The bench keeps to this by writing the masks and the control register only while the detector is disabled, or with the inputs held quiet. It drives each input and each bus access at the falling clock edge, so every synchroniser stage advances exactly once per rising edge.

// File: rtl/cosirq_pkg.sv
// Package: register offsets and control field positions shared by the
// change-of-state detector modules.
package cosirq_pkg;
    localparam int              REG_AW       = 4;
    localparam logic [REG_AW-1:0] OFS_CTRL   = 4'h0;
    localparam logic [REG_AW-1:0] OFS_HIMASK = 4'h4;
    localparam logic [REG_AW-1:0] OFS_LOMASK = 4'h8;
    localparam logic [REG_AW-1:0] OFS_STAT   = 4'hC;
    localparam int              CTRL_EN_BIT  = 2;
    localparam int              CTRL_AND_BIT = 1;
endpackage

// File: rtl/cos_sync_bank.sv
// Module: cos_sync_bank
// Brings each asynchronous channel into the clock domain through two flops.
// It keeps one further history flop so that edges can be seen.
// Assumes: inputs are static single-bit levels; no cross-channel skew matters.
module cos_sync_bank #(
    parameter int NCH = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] raw_in,
    output logic [NCH-1:0] lvl,
    output logic [NCH-1:0] rise,
    output logic [NCH-1:0] fall
);
    genvar g;
    generate
        for (g = 0; g < NCH; g++) begin : g_ch
            logic meta_q, sync_q, prev_q;
            // Two-stage synchroniser plus one history stage per channel
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta_q <= 1'b0;
                    sync_q <= 1'b0;
                    prev_q <= 1'b0;
                end else begin
                    meta_q <= raw_in[g];
                    sync_q <= meta_q;
                    prev_q <= sync_q;
                end
            end
            assign lvl[g]  = sync_q;
            assign rise[g] = sync_q & ~prev_q;
            assign fall[g] = ~sync_q & prev_q;
        end
    endgenerate
endmodule

// File: rtl/cos_match.sv
// Module: cos_match
// Combines the synchronised channels with the two masks into one trigger
// condition, and lists the channels that take part in it.
// Assumes: lvl/rise/fall come from the same synchroniser sample.
module cos_match #(
    parameter int NCH = 16
) (
    input  logic           mode_and,
    input  logic [NCH-1:0] hi_mask,
    input  logic [NCH-1:0] lo_mask,
    input  logic [NCH-1:0] lvl,
    input  logic [NCH-1:0] rise,
    input  logic [NCH-1:0] fall,
    output logic           cond,
    output logic [NCH-1:0] hits
);
    logic [NCH-1:0] selected;
    logic [NCH-1:0] level_ok;

    // Per-channel level agreement; unselected channels always agree
    always_comb begin
        selected = hi_mask | lo_mask;
        level_ok = (~hi_mask | lvl) & (~lo_mask | ~lvl);
    end

    // Mode-dependent combining of the per-channel results
    always_comb begin
        if (mode_and) begin
            cond = (|selected) && (&level_ok);
            hits = cond ? selected : '0;
        end else begin
            hits = (rise & hi_mask) | (fall & lo_mask);
            cond = |hits;
        end
    end
endmodule

// File: rtl/cos_irq_latch.sv
// Module: cos_irq_latch
// Holds the sticky interrupt, the status record and the AND-mode re-arm flag.
// Assumes: rd_clr is a one-cycle pulse per status read.
module cos_irq_latch #(
    parameter int NCH = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en,
    input  logic           mode_and,
    input  logic           cond,
    input  logic [NCH-1:0] hits,
    input  logic           rd_clr,
    output logic           irq,
    output logic [NCH-1:0] stat
);
    logic armed_q;
    logic fire;

    // A firing needs enable, a condition, and (in AND mode) a released detector
    always_comb fire = en && cond && (!mode_and || armed_q);

    // Sticky request and status record with clear-on-read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq  <= 1'b0;
            stat <= '0;
        end else if (fire) begin
            irq  <= 1'b1;
            stat <= rd_clr ? hits : (stat | hits);
        end else if (rd_clr) begin
            irq  <= 1'b0;
            stat <= '0;
        end
    end

    // Re-arm flag: dropped by an AND firing, restored once the condition falls
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed_q <= 1'b1;
        else if (fire && mode_and)
            armed_q <= 1'b0;
        else if (!cond)
            armed_q <= 1'b1;
    end

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !rd_clr) |=> irq); // R9
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !cond) |=> (!irq && stat == '0)); // R9
    AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (stat != '0)); // R9
    AST_IDLE_NO_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> (stat == '0)); // R1
    AST_GATED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !$rose(irq)); // R10
    AST_AND_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_and && !armed_q) |=> !$rose(irq)); // R7
endmodule

// File: rtl/cos_irq_detector.sv
// Module: cos_irq_detector (top)
// Register bank plus the synchroniser, matcher and latch of a change-of-state
// interrupt detector over NCH input channels.
// Assumes: single-cycle bus accesses; read data is taken while bus_sel is high.
module cos_irq_detector
    import cosirq_pkg::*;
#(
    parameter int NCH = 16,
    parameter int DW  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [NCH-1:0]    chan_in,
    output logic              irq
);
    logic           ctrl_en_q, ctrl_and_q;
    logic [NCH-1:0] hi_mask_q, lo_mask_q;
    logic [NCH-1:0] lvl, rise, fall, hits, stat;
    logic           cond, wr_en, rd_stat;
    logic           unused_wdata;

    assign unused_wdata = ^bus_wdata[DW-1:NCH];

    // Decode of bus strobes
    always_comb begin
        wr_en   = bus_sel && bus_we;
        rd_stat = bus_sel && !bus_we && (bus_addr == OFS_STAT);
    end

    // Control and mask registers written from the bus
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_en_q  <= 1'b0;
            ctrl_and_q <= 1'b0;
            hi_mask_q  <= '0;
            lo_mask_q  <= '0;
        end else if (wr_en) begin
            case (bus_addr)
                OFS_CTRL: begin
                    ctrl_en_q  <= bus_wdata[CTRL_EN_BIT];
                    ctrl_and_q <= bus_wdata[CTRL_AND_BIT];
                end
                OFS_HIMASK: hi_mask_q <= bus_wdata[NCH-1:0];
                OFS_LOMASK: lo_mask_q <= bus_wdata[NCH-1:0];
                default: ;
            endcase
        end
    end

    // Read multiplexer, zero when no read is in progress
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_we) begin
            case (bus_addr)
                OFS_CTRL: begin
                    bus_rdata[CTRL_EN_BIT]  = ctrl_en_q;
                    bus_rdata[CTRL_AND_BIT] = ctrl_and_q;
                end
                OFS_HIMASK: bus_rdata[NCH-1:0] = hi_mask_q;
                OFS_LOMASK: bus_rdata[NCH-1:0] = lo_mask_q;
                OFS_STAT:   bus_rdata[NCH-1:0] = stat;
                default: ;
            endcase
        end
    end

    cos_sync_bank #(.NCH(NCH)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw_in(chan_in),
        .lvl(lvl), .rise(rise), .fall(fall)
    );

    cos_match #(.NCH(NCH)) u_match (
        .mode_and(ctrl_and_q), .hi_mask(hi_mask_q), .lo_mask(lo_mask_q),
        .lvl(lvl), .rise(rise), .fall(fall), .cond(cond), .hits(hits)
    );

    cos_irq_latch #(.NCH(NCH)) u_latch (
        .clk(clk), .rst_n(rst_n), .en(ctrl_en_q), .mode_and(ctrl_and_q),
        .cond(cond), .hits(hits), .rd_clr(rd_stat), .irq(irq), .stat(stat)
    );

    AST_STAT_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ((stat & ~$past(hi_mask_q | lo_mask_q)) == '0)); // R3
    AST_AND_STAT_UNION: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq) && $past(ctrl_and_q)) |-> (stat == $past(hi_mask_q | lo_mask_q))); // R6
    AST_AND_BOTH_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_and_q && ((hi_mask_q & lo_mask_q) != '0)) |=> !$rose(irq)); // R8
endmodule

// File: tb/sim_cos_irq_detector.sv
module sim_cos_irq_detector;
    localparam int CLK_P = 10;
    localparam int NCH   = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic [15:0] chan_in = 16'h0;
    logic        irq;
    int          checks = 0, errors = 0;
    bit          done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    cos_irq_detector u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .chan_in(chan_in), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic quiesce();
        logic [31:0] d;
        wr(4'h0, 32'h0);
        chan_in = 16'h0;
        idle(4);
        rd(4'hC, d);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        chk("R1 irq", {31'h0, irq}, 32'h0);
        for (int a = 0; a < 4; a++) begin
            rd(4'(a * 4), d);
            chk("R1 reg", d, 32'h0);
        end
        // R2 field widths and status write ignored
        wr(4'h0, 32'hFFFF_FFF9); rd(4'h0, d); chk("R2 ctrl", d, 32'h0);
        wr(4'h0, 32'hFFFF_FFFF); rd(4'h0, d); chk("R2 ctrl", d, 32'h6);
        wr(4'h0, 32'h0);
        wr(4'h4, 32'hFFFF_FFFF); rd(4'h4, d); chk("R2 himask", d, 32'hFFFF);
        wr(4'h8, 32'hA5A5_5A5A); rd(4'h8, d); chk("R2 lomask", d, 32'h5A5A);
        wr(4'hC, 32'hFFFF_FFFF); rd(4'hC, d); chk("R2 status", d, 32'h0);
        // R10 disabled: toggling all inputs with masks set does nothing
        chan_in = 16'hFFFF; idle(5); chk("R10 off rise", {31'h0, irq}, 32'h0);
        chan_in = 16'h0;    idle(5); chk("R10 off fall", {31'h0, irq}, 32'h0);
        wr(4'h0, 32'h2);
        chan_in = 16'hFFFF; idle(5); chk("R10 and-off", {31'h0, irq}, 32'h0);
        quiesce();

        // R3/R5 OR rising sweep over every channel
        for (int c = 0; c < NCH; c++) begin
            logic [15:0] bit_c, bit_n;
            bit_c = 16'(1) << c;
            bit_n = 16'(1) << ((c + 1) % NCH);
            wr(4'h4, {16'h0, bit_c}); wr(4'h8, 32'h0); wr(4'h0, 32'h4);
            chan_in = bit_n; idle(4);
            chan_in = 16'h0; idle(4);
            chk("R5 unselected", {31'h0, irq}, 32'h0);
            chan_in = bit_c; idle(2);
            chk("R3 early", {31'h0, irq}, 32'h0);
            idle(1);
            chk("R3 irq", {31'h0, irq}, 32'h1);
            rd(4'hC, d); chk("R3 status", d, {16'h0, bit_c});
            chk("R9 cleared", {31'h0, irq}, 32'h0);
            chan_in = 16'h0; idle(4);
            chk("R3 no fall", {31'h0, irq}, 32'h0);
            quiesce();
        end

        // R4 OR falling sweep
        for (int c = 0; c < NCH; c++) begin
            logic [15:0] bit_c;
            bit_c = 16'(1) << c;
            wr(4'h4, 32'h0); wr(4'h8, {16'h0, bit_c}); wr(4'h0, 32'h4);
            chan_in = bit_c; idle(4);
            chk("R4 no rise", {31'h0, irq}, 32'h0);
            chan_in = 16'h0; idle(2);
            chk("R4 early", {31'h0, irq}, 32'h0);
            idle(1);
            chk("R4 irq", {31'h0, irq}, 32'h1);
            rd(4'hC, d); chk("R4 status", d, {16'h0, bit_c});
            quiesce();
        end

        // R5 channel in both masks fires on both edges
        wr(4'h4, 32'h0080); wr(4'h8, 32'h0080); wr(4'h0, 32'h4);
        chan_in = 16'h0080; idle(3);
        chk("R5 both rise", {31'h0, irq}, 32'h1);
        rd(4'hC, d); chk("R5 both rise st", d, 32'h0080);
        chan_in = 16'h0; idle(3);
        chk("R5 both fall", {31'h0, irq}, 32'h1);
        rd(4'hC, d); chk("R5 both fall st", d, 32'h0080);
        quiesce();

        // R6/R7 AND sweep
        for (int i = 0; i < NCH; i++) begin
            logic [15:0] hm, lm;
            hm = 16'(1) << i;
            lm = 16'(1) << ((i + 5) % NCH);
            wr(4'h4, {16'h0, hm}); wr(4'h8, {16'h0, lm}); wr(4'h0, 32'h6);
            idle(4);
            chk("R6 not met", {31'h0, irq}, 32'h0);
            chan_in = hm | lm; idle(4);
            chk("R6 low unmet", {31'h0, irq}, 32'h0);
            chan_in = hm; idle(2);
            chk("R6 early", {31'h0, irq}, 32'h0);
            idle(1);
            chk("R6 irq", {31'h0, irq}, 32'h1);
            rd(4'hC, d); chk("R6 status", d, {16'h0, hm | lm});
            idle(6);
            chk("R7 holdoff", {31'h0, irq}, 32'h0);
            chan_in = 16'h0; idle(4);
            chk("R7 released", {31'h0, irq}, 32'h0);
            chan_in = hm; idle(3);
            chk("R7 refire", {31'h0, irq}, 32'h1);
            rd(4'hC, d); chk("R7 refire st", d, {16'h0, hm | lm});
            quiesce();
        end

        // R8 AND with a channel in both masks, and with empty masks
        wr(4'h4, 32'h0009); wr(4'h8, 32'h0008); wr(4'h0, 32'h6);
        chan_in = 16'h0009; idle(5);
        chk("R8 both hi", {31'h0, irq}, 32'h0);
        chan_in = 16'h0001; idle(5);
        chk("R8 both lo", {31'h0, irq}, 32'h0);
        quiesce();
        wr(4'h4, 32'h0); wr(4'h8, 32'h0); wr(4'h0, 32'h6);
        chan_in = 16'hFFFF; idle(5);
        chan_in = 16'h0;    idle(5);
        chk("R8 empty", {31'h0, irq}, 32'h0);
        quiesce();

        // R9 sticky across idle time, and a firing coinciding with a read
        wr(4'h4, 32'h0003); wr(4'h8, 32'h0); wr(4'h0, 32'h4);
        chan_in = 16'h0001; idle(3);
        idle(10);
        chk("R9 sticky", {31'h0, irq}, 32'h1);
        chan_in = 16'h0003; idle(2);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 4'hC;
        #1 d = bus_rdata;
        chk("R9 old status", d, 32'h0001);
        @(posedge clk); @(negedge clk);
        bus_sel = 1'b0;
        chk("R9 kept irq", {31'h0, irq}, 32'h1);
        rd(4'hC, d); chk("R9 new status", d, 32'h0002);
        chk("R9 clear", {31'h0, irq}, 32'h0);
        // R10 control written to zero stops further firing
        wr(4'h0, 32'h0);
        chan_in = 16'h0; idle(2);
        chan_in = 16'h0003; idle(5);
        chk("R10 zero ctrl", {31'h0, irq}, 32'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule